// File: doc/BRIEF.md
# Fractional-N Divide-Ratio Sequencer

This block works out, once per phase-detector reference cycle, which integer division ratio the PLL feedback counter uses next. It holds an integer part, a fractional numerator and a programmable denominator. A third-order noise-shaping modulator is built from three cascaded accumulators. Each accumulator wraps at the programmed denominator rather than at a power of two. Their carries are combined into a small signed correction, and that correction is added to the integer part. The long-run mean of the issued ratios is INT + FRAC/MOD, so the output channel step is the reference frequency divided by MOD.

The configuration takes effect only when the load strobe is asserted. At that moment the modulator restarts from a clean state, so a partly written configuration is never used. A narrow mode uses 12-bit numerator and denominator fields. A wide mode uses 16-bit fields. A zero numerator selects plain integer division. An optional one-LSB pseudo-random dither can be injected into the first accumulator to break up the spurious tones that a deterministic sequence produces. The `step` input is pulsed once per reference cycle.

Top module: `fnd_sdm_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset until the first load, `div_ratio` and `div_offset` are 0.
- R2: When `cfg_load` is high at a clock edge, the block captures INT, FRAC, MOD and the width mode. At the same edge it clears all three accumulators and the carry history, and it reseeds the dither generator. In the next cycle `div_ratio` equals INT and `div_offset` is 0. A `step` at the same edge is ignored.
- R3: With `cfg_wide` = 0, only bits [11:0] of `cfg_frac` and `cfg_mod` are used and the upper four bits are treated as zero. With `cfg_wide` = 1, all 16 bits are used.
- R4: Integer mode applies when the captured FRAC is 0, when MOD is below 2, or when FRAC is not below MOD. In integer mode every step gives `div_ratio` = INT and `div_offset` = 0, whatever the value of `dither_en`.
- R5: In fractional mode each step updates three accumulators, in stage order. Stage 1 adds FRAC plus the dither bit. Stage 2 adds stage 1's new value. Stage 3 adds stage 2's new value. When a stage's sum is MOD or larger, that stage subtracts MOD and its carry is 1; otherwise its carry is 0. Each accumulator always stays below MOD.
- R6: On each fractional step, `div_offset` = c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where a prime marks the carry from one step earlier and a double prime the carry from two steps earlier (0 after a load). The offset lies in −3..+4. `div_ratio` = (INT + offset) mod 2^17. Both outputs are registered at the step edge.
- R7: In a cycle with neither `step` nor `cfg_load`, `div_ratio` and `div_offset` keep their values.
- R8: The dither generator is a 16-bit shift register seeded with 0xACE1. At each step it shifts left and feeds in bits 15^13^12^10. The bit added at a step is bit 0 of its state before that shift. It advances on every step, and its bit is added only when `dither_en` is high at that step.
- R9: With dither off, after k steps from a load, the sum of the issued ratios minus (k·INT + floor(k·FRAC/MOD)) lies in −1..+2. For k = MOD, this means the sum is INT·MOD + FRAC within that bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Captures the configuration and restarts the modulator |
| cfg_int | input | 16 | Integer part of the ratio |
| cfg_frac | input | 16 | Fractional numerator |
| cfg_mod | input | 16 | Modulus denominator |
| cfg_wide | input | 1 | 1 selects 16-bit FRAC/MOD, 0 selects 12-bit |
| dither_en | input | 1 | Adds the pseudo-random LSB into stage 1 |
| step | input | 1 | One pulse per reference cycle; advances the modulator |
| div_ratio | output | 17 | Divide ratio for the next reference cycle |
| div_offset | output | 4 | Signed correction applied to INT for that ratio |

## Verification
The hardest condition to reach is the one where the stage-1 addend equals MOD exactly. This happens when FRAC is MOD−1 and the dither bit is 1. The sum then sits on the wrap boundary, and the extreme offsets of −3 and +4 need an unusual carry pattern across all three stages. The stimulus reaches these cases with very small moduli (2 to 5), FRAC set to MOD−1 and dither enabled, which makes the boundary sums frequent. Wide moduli of several tens of thousands, together with 12-bit masking of inputs whose upper bits are set, cover the width switch.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

  localparam int FND_INT_W    = 16;
  localparam int FND_FRAC_W   = 16;
  localparam int FND_NARROW_W = 12;
  localparam int FND_STAGES   = 3;
  localparam logic [15:0] FND_LFSR_SEED = 16'hACE1;

  // Noise-shaping combination of the stage carries:
  // c1 + first difference of c2 + second difference of c3.
  function automatic logic signed [3:0] mash_offset(
    input logic [2:0] c_now,
    input logic       c2_p,
    input logic       c3_p,
    input logic       c3_pp
  );
    logic signed [3:0] t1, t2, t3;
    t1 = $signed({3'b000, c_now[0]});
    t2 = $signed({3'b000, c_now[1]}) - $signed({3'b000, c2_p});
    t3 = $signed({3'b000, c_now[2]}) - $signed({2'b00, c3_p, 1'b0})
       + $signed({3'b000, c3_pp});
    return t1 + t2 + t3;
  endfunction

  // Fibonacci shift, taps 15, 13, 12, 10.
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/fnd_mod_accum.sv
module fnd_mod_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] mod_i,
  input  logic [W:0]   addend_i,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] acc_next,
  output logic         carry_o
);

  logic [W:0] sum_raw;
  logic [W:0] sum_wrap;

  always_comb begin
    sum_raw  = {1'b0, acc_q} + addend_i;
    sum_wrap = sum_raw - {1'b0, mod_i};
    carry_o  = (sum_raw >= {1'b0, mod_i});
    acc_next = carry_o ? sum_wrap[W-1:0] : sum_raw[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else if (adv) acc_q <= acc_next;
  end

  // R5
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_i != '0) |-> (acc_q < mod_i));

endmodule

// File: rtl/fnd_dither_lfsr.sv
module fnd_dither_lfsr
  import fnd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reseed,
  input  logic adv,
  output logic bit_o
);

  logic [15:0] st_q;

  assign bit_o = st_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= FND_LFSR_SEED;
    else if (reseed) st_q <= FND_LFSR_SEED;
    else if (adv)    st_q <= lfsr_step(st_q);
  end

  // R8
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 16'h0000);

endmodule

// File: rtl/fnd_noise_shaper.sv
module fnd_noise_shaper
  import fnd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [2:0]        carry_i,
  output logic signed [3:0] offset_o
);

  logic c2_p, c3_p, c3_pp;

  assign offset_o = mash_offset(carry_i, c2_p, c3_p, c3_pp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_p <= 1'b0; c3_p <= 1'b0; c3_pp <= 1'b0;
    end else if (clr) begin
      c2_p <= 1'b0; c3_p <= 1'b0; c3_pp <= 1'b0;
    end else if (adv) begin
      c2_p  <= carry_i[1];
      c3_pp <= c3_p;
      c3_p  <= carry_i[2];
    end
  end

  // R6
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (offset_o >= -4'sd3) && (offset_o <= 4'sd4));

endmodule

// File: rtl/fnd_sdm_ctrl.sv
module fnd_sdm_ctrl
  import fnd_pkg::*;
#(
  parameter int INT_W    = FND_INT_W,
  parameter int FRAC_W   = FND_FRAC_W,
  parameter int NARROW_W = FND_NARROW_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic [INT_W-1:0]       cfg_int,
  input  logic [FRAC_W-1:0]      cfg_frac,
  input  logic [FRAC_W-1:0]      cfg_mod,
  input  logic                   cfg_wide,
  input  logic                   dither_en,
  input  logic                   step,
  output logic [INT_W:0]         div_ratio,
  output logic signed [3:0]      div_offset
);

  localparam int RAT_W = INT_W + 1;
  localparam logic [FRAC_W-1:0] NARROW_MASK =
    {{(FRAC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q, mod_q;
  logic [FRAC_W-1:0] field_mask;
  logic              int_mode, adv, run, dith_bit, lfsr_bit;
  logic [FND_STAGES-1:0] carry;
  logic [FRAC_W:0]   addend   [FND_STAGES];
  logic [FRAC_W-1:0] acc_next [FND_STAGES];
  logic [FRAC_W-1:0] acc_q    [FND_STAGES];
  logic signed [3:0] shaped_off, applied_off;

  assign field_mask = cfg_wide ? {FRAC_W{1'b1}} : NARROW_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= '0; frac_q <= '0; mod_q <= '0;
    end else if (cfg_load) begin
      int_q  <= cfg_int;
      frac_q <= cfg_frac & field_mask;
      mod_q  <= cfg_mod & field_mask;
    end
  end

  assign int_mode = (frac_q == '0) || (mod_q < FRAC_W'(2)) || (frac_q >= mod_q);
  assign adv      = step && !cfg_load;
  assign run      = adv && !int_mode;
  assign dith_bit = dither_en && lfsr_bit;

  fnd_dither_lfsr u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .reseed (cfg_load),
    .adv    (adv),
    .bit_o  (lfsr_bit)
  );

  for (genvar s = 0; s < FND_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign addend[s] = {1'b0, frac_q} + {{FRAC_W{1'b0}}, dith_bit};
    end else begin : g_tail
      assign addend[s] = {1'b0, acc_next[s-1]};
    end
    fnd_mod_accum #(.W(FRAC_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cfg_load),
      .adv      (run),
      .mod_i    (mod_q),
      .addend_i (addend[s]),
      .acc_q    (acc_q[s]),
      .acc_next (acc_next[s]),
      .carry_o  (carry[s])
    );
  end

  fnd_noise_shaper u_shape (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cfg_load),
    .adv      (run),
    .carry_i  (carry),
    .offset_o (shaped_off)
  );

  assign applied_off = int_mode ? 4'sd0 : shaped_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_ratio  <= '0;
      div_offset <= '0;
    end else if (cfg_load) begin
      div_ratio  <= {1'b0, cfg_int};
      div_offset <= '0;
    end else if (adv) begin
      div_ratio  <= {1'b0, int_q} + {{(RAT_W-4){applied_off[3]}}, applied_off};
      div_offset <= applied_off;
    end
  end

  // R2
  load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (div_ratio == {1'b0, $past(cfg_int)}) && (div_offset == 4'sd0));

  // R4
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && int_mode) |=> (div_offset == 4'sd0) && (div_ratio == {1'b0, $past(int_q)}));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cfg_load) |=> $stable(div_ratio) && $stable(div_offset));

endmodule

// File: tb/sim_fnd_sdm_ctrl.sv
module sim_fnd_sdm_ctrl;

  logic        clk = 1'b0;
  logic        rst_n, cfg_load, cfg_wide, dither_en, step;
  logic [15:0] cfg_int, cfg_frac, cfg_mod;
  logic [16:0] div_ratio;
  logic signed [3:0] div_offset;

  always #4 clk = ~clk;

  fnd_sdm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_int(cfg_int),
    .cfg_frac(cfg_frac), .cfg_mod(cfg_mod), .cfg_wide(cfg_wide),
    .dither_en(dither_en), .step(step), .div_ratio(div_ratio),
    .div_offset(div_offset)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference state
  int m_int, m_frac, m_mod;
  int acc [3];
  int cp2, cp3, cpp3;
  bit [15:0] lf;
  bit m_intmode;
  int exp_ratio, exp_off;
  longint run_sum;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    check({tag, " ratio"}, longint'(div_ratio), longint'(exp_ratio));
    check({tag, " offset"}, longint'(div_offset), longint'(exp_off));
  endtask

  task automatic do_load(input int iv, input int fv, input int mv, input bit w,
                         input bit with_step);
    @(negedge clk);
    cfg_int = 16'(iv); cfg_frac = 16'(fv); cfg_mod = 16'(mv); cfg_wide = w;
    cfg_load = 1'b1; step = with_step;
    @(negedge clk);
    cfg_load = 1'b0; step = 1'b0;
    m_int  = iv & 32'hFFFF;
    m_frac = w ? (fv & 32'hFFFF) : (fv & 32'hFFF);
    m_mod  = w ? (mv & 32'hFFFF) : (mv & 32'hFFF);
    m_intmode = (m_frac == 0) || (m_mod < 2) || (m_frac >= m_mod);
    foreach (acc[i]) acc[i] = 0;
    cp2 = 0; cp3 = 0; cpp3 = 0;
    lf = 16'hACE1;
    exp_ratio = m_int; exp_off = 0; run_sum = 0;
    check_outputs("R2 load");
  endtask

  function automatic void model_step(input bit dith);
    int d, s, c1, c2, c3, off;
    d  = (dith && lf[0]) ? 1 : 0;
    lf = {lf[14:0], ^(lf & 16'hB400)};
    if (m_intmode) begin
      exp_ratio = m_int; exp_off = 0;
    end else begin
      s = acc[0] + m_frac + d; c1 = s / m_mod; acc[0] = s % m_mod;
      s = acc[1] + acc[0];     c2 = s / m_mod; acc[1] = s % m_mod;
      s = acc[2] + acc[1];     c3 = s / m_mod; acc[2] = s % m_mod;
      off = c1 + (c2 - cp2) + (c3 - 2 * cp3 + cpp3);
      cpp3 = cp3; cp3 = c3; cp2 = c2;
      exp_off = off;
      exp_ratio = (m_int + off) & 32'h1FFFF;
    end
    run_sum += exp_ratio;
  endfunction

  task automatic do_step(input bit dith, input string tag);
    @(negedge clk);
    step = 1'b1; dither_en = dith;
    @(negedge clk);
    step = 1'b0;
    model_step(dith);
    check_outputs(tag);
  endtask

  task automatic window_check(input int iv, input int fv, input int mv, input bit w);
    longint base, err;
    int half;
    bit ok;
    do_load(iv, fv, mv, w, 1'b0);
    half = m_mod / 2;
    for (int k = 1; k <= m_mod; k++) begin
      do_step(1'b0, "R6 window");
      if (k == half || k == m_mod) begin
        base = longint'(k) * m_int + (longint'(k) * m_frac) / m_mod;
        err  = run_sum - base;
        ok   = (err >= -1) && (err <= 2);
        check("R9 cumulative bound", ok ? err : err + 1000, err);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_load = 1'b0; step = 1'b0; dither_en = 1'b0;
    cfg_int = '0; cfg_frac = '0; cfg_mod = '0; cfg_wide = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset ratio", longint'(div_ratio), 0);
    check("R1 reset offset", longint'(div_offset), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 post-reset ratio", longint'(div_ratio), 0);

    // R5 R6 directed: quarter fraction
    do_load(100, 1, 4, 1'b0, 1'b0);
    for (int k = 0; k < 40; k++) do_step(1'b0, "R5 quarter");

    // R7 idle cycles hold outputs
    repeat (5) @(negedge clk);
    check_outputs("R7 idle");

    // R4 integer mode variants, dither on
    do_load(777, 0, 100, 1'b1, 1'b0);
    for (int k = 0; k < 10; k++) do_step(1'b1, "R4 frac zero");
    do_load(500, 9, 9, 1'b1, 1'b0);
    for (int k = 0; k < 10; k++) do_step(1'b1, "R4 frac ge mod");
    do_load(321, 1, 1, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) do_step(1'b1, "R4 mod one");

    // R3 narrow masking with upper bits set, then wide
    do_load(2000, 16'hF123, 16'hF7D0, 1'b0, 1'b0);
    for (int k = 0; k < 60; k++) do_step(1'b0, "R3 narrow");
    do_load(2000, 12345, 50000, 1'b1, 1'b0);
    for (int k = 0; k < 60; k++) do_step(1'b0, "R3 wide");

    // R8 dither at the wrap boundary, small moduli
    for (int m = 2; m <= 5; m++) begin
      do_load(40, m - 1, m, 1'b0, 1'b0);
      for (int k = 0; k < 50; k++) do_step(1'b1, "R8 boundary dither");
    end

    // R2 load with simultaneous step, then reload mid-run
    do_load(60, 3, 7, 1'b0, 1'b1);
    for (int k = 0; k < 9; k++) do_step(1'b0, "R2 after load");
    do_load(61, 5, 11, 1'b0, 1'b0);
    for (int k = 0; k < 15; k++) do_step(1'b1, "R2 reload");

    // R9 windows: directed then random
    window_check(1000, 1, 3, 1'b0);
    window_check(250, 199, 200, 1'b0);
    for (int t = 0; t < 15; t++) begin
      int mv, fv, iv;
      mv = 2 + int'($urandom % 299);
      fv = 1 + int'($urandom % (mv - 1));
      iv = 3 + int'($urandom % 60000);
      window_check(iv, fv, mv, t[0]);
    end

    // R5 R8 random configs, random dither
    for (int t = 0; t < 20; t++) begin
      int mv, fv;
      bit w;
      w  = $urandom % 2;
      mv = 2 + int'($urandom % (w ? 65534 : 4094));
      fv = int'($urandom % mv);
      do_load(3 + int'($urandom % 65000), fv, mv, w, 1'b0);
      for (int k = 0; k < 80; k++) do_step(bit'($urandom % 2), "R8 random");
      @(negedge clk);
      check_outputs("R7 gap");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule